// File: doc/BRIEF.md
# Prescaler-Selectable Low-Rate PWM Timer

This block makes a single pulse-width-modulated output from a slow tick, nominally 32 kHz, given as a one-cycle clock enable. An 8-bit counter advances on each tick. It returns to zero when a chosen counter bit would become set, so a 2-bit prescaler selects one of four periods: 128, 64, 32 or 16 ticks. At a 32 kHz tick these are 250 Hz, 500 Hz, 1 kHz and 2 kHz. A 7-bit duty count gives the number of ticks per period for which the output is high.

Software uses a small byte-wide register port. It has a control register and a duty register. The control register holds an enable flag and the prescaler. Register writes act at once. Changing the prescaler does not clear the counter, and a new duty value is used by the comparison in the very next cycle, even in the middle of a period.

Top module: `tick_pwm`

## Requirements
- R1: After reset, both registers read zero, the output is low and the counter is zero.
- R2: Address 0 is control, with enable in bit 7 and the prescaler in bits 1:0. Address 1 holds the duty count in bits 6:0. Addresses 2 and 3 read as zero. Read data shows the register selected by the address one clock after that address is presented. A write takes effect on the clock edge at which reg_we is high.
- R3: Control bits 6:2 and duty bit 7 always read zero, and writing ones to them has no effect.
- R4: While enabled, the counter advances only on cycles where tick is high. With prescaler p, the counter returns to zero when its incremented value has bit 7-p set, so the period is 2^(7-p) ticks.
- R5: The output is high exactly when enable is set and the counter bits below the reset bit, taken as a number, are less than the duty count. A duty count at or above the period gives a constant high output. With prescaler 0, a duty of 127 gives 127 high ticks out of 128. A duty of 0 gives a constant low output.
- R6: While enable is 0, the output is low and the counter is held at zero. After enable is set, counting starts from zero.
- R7: Writing a new prescaler leaves the counter value unchanged. Counting continues from that value until an increment sets the new reset bit.
- R8: A new duty value controls the output from the cycle after the write, without waiting for the end of the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at the PWM time base |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, for the previous cycle's address |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check, on every cycle, the following behaviour:
- the disabled output is low and the counter is cleared;
- the counter only holds, steps by one or wraps;
- the two duty extremes force the output;
- reserved and unmapped read-back bits are zero.

Some behaviour cannot be seen by looking at one or two cycles, so only the bench's scenarios show it:
- the actual period for each prescaler;
- the exact high-tick count at prescaler 0 with full duty;
- the counter's continuation across a prescaler change;
- the immediate effect of a duty write.

The bench shows these by counting high cycles over windows and comparing against a cycle model.

// File: rtl/tick_pwm_pkg.sv
package tick_pwm_pkg;

  // Counter and field widths
  localparam int CNT_W  = 8;
  localparam int DUTY_W = CNT_W - 1;
  localparam int PSC_W  = 2;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  // Register map
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 2'd1;

  // Bit position of the enable flag inside the control register
  localparam int CTRL_EN_BIT = 7;

  typedef struct packed {
    logic             en;
    logic [PSC_W-1:0] psc;
  } ctrl_t;

endpackage

// File: rtl/tick_pwm_regs.sv
module tick_pwm_regs
  import tick_pwm_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W,
  parameter int P_PSC_W  = PSC_W,
  parameter int P_DUTY_W = DUTY_W,
  parameter int P_EN_BIT = CTRL_EN_BIT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P_ADDR_W-1:0] reg_addr,
  input  logic                reg_we,
  input  logic [P_DATA_W-1:0] reg_wdata,
  output logic [P_DATA_W-1:0] reg_rdata,
  output logic                ctrl_en,
  output logic [P_PSC_W-1:0]  ctrl_psc,
  output logic [P_DUTY_W-1:0] duty
);

  logic                en_q;
  logic [P_PSC_W-1:0]  psc_q;
  logic [P_DUTY_W-1:0] duty_q;
  logic [P_DATA_W-1:0] rd_q;
  logic [P_DATA_W-1:0] rd_nxt;
  logic                hit_ctrl;
  logic                hit_duty;

  assign hit_ctrl = reg_we && (reg_addr == P_ADDR_W'(ADDR_CTRL));
  assign hit_duty = reg_we && (reg_addr == P_ADDR_W'(ADDR_DUTY));

  // Writable fields only; reserved bits have no storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      psc_q  <= '0;
      duty_q <= '0;
    end else begin
      if (hit_ctrl) begin
        en_q  <= reg_wdata[P_EN_BIT];
        psc_q <= reg_wdata[P_PSC_W-1:0];
      end
      if (hit_duty) begin
        duty_q <= reg_wdata[P_DUTY_W-1:0];
      end
    end
  end

  // Read mux: shows the stored value before this cycle's write
  always_comb begin
    rd_nxt = '0;
    if (reg_addr == P_ADDR_W'(ADDR_CTRL)) begin
      rd_nxt[P_EN_BIT]        = en_q;
      rd_nxt[P_PSC_W-1:0]     = psc_q;
    end else if (reg_addr == P_ADDR_W'(ADDR_DUTY)) begin
      rd_nxt[P_DUTY_W-1:0]    = duty_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_nxt;
  end

  assign reg_rdata = rd_q;
  assign ctrl_en   = en_q;
  assign ctrl_psc  = psc_q;
  assign duty      = duty_q;

endmodule

// File: rtl/tick_pwm_counter.sv
module tick_pwm_counter
  import tick_pwm_pkg::*;
#(
  parameter int P_CNT_W = CNT_W,
  parameter int P_PSC_W = PSC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic [P_PSC_W-1:0] psc,
  output logic [P_CNT_W-1:0] cnt,
  output logic [P_CNT_W-1:0] low_mask
);

  localparam int NSEL = 1 << P_PSC_W;

  logic [P_CNT_W-1:0] rst_bit_tab [NSEL];
  logic [P_CNT_W-1:0] mask_tab    [NSEL];
  logic [P_CNT_W-1:0] cnt_q;
  logic [P_CNT_W-1:0] cnt_inc;
  logic [P_CNT_W-1:0] sel_bit;
  logic               wrap;

  // One reset-bit and below-bit mask per prescaler setting
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    localparam logic [P_CNT_W-1:0] ONE_HOT =
      P_CNT_W'(1) << (P_CNT_W - 1 - g);
    assign rst_bit_tab[g] = ONE_HOT;
    assign mask_tab[g]    = ONE_HOT - P_CNT_W'(1);
  end

  assign sel_bit  = rst_bit_tab[psc];
  assign low_mask = mask_tab[psc];
  assign cnt_inc  = cnt_q + P_CNT_W'(1);
  assign wrap     = |(cnt_inc & sel_bit);

  // Prescaler changes never clear the count; only the wrap test moves
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (tick)   cnt_q <= wrap ? '0 : cnt_inc;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tick_pwm_cmp.sv
module tick_pwm_cmp
  import tick_pwm_pkg::*;
#(
  parameter int P_CNT_W  = CNT_W,
  parameter int P_DUTY_W = DUTY_W
) (
  input  logic                en,
  input  logic [P_CNT_W-1:0]  cnt,
  input  logic [P_CNT_W-1:0]  low_mask,
  input  logic [P_DUTY_W-1:0] duty,
  output logic                pwm
);

  logic [P_CNT_W-1:0] phase;
  logic [P_CNT_W-1:0] duty_ext;

  // Only the bits under the active reset bit count as the phase
  assign phase    = cnt & low_mask;
  assign duty_ext = P_CNT_W'(duty);
  assign pwm      = en && (phase < duty_ext);

endmodule

// File: rtl/tick_pwm.sv
module tick_pwm
  import tick_pwm_pkg::*;
#(
  parameter int P_CNT_W  = CNT_W,
  parameter int P_PSC_W  = PSC_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [P_ADDR_W-1:0] reg_addr,
  input  logic                reg_we,
  input  logic [P_DATA_W-1:0] reg_wdata,
  output logic [P_DATA_W-1:0] reg_rdata,
  output logic                pwm_out
);

  localparam int L_DUTY_W = P_CNT_W - 1;

  logic                ctrl_en;
  logic [P_PSC_W-1:0]  ctrl_psc;
  logic [L_DUTY_W-1:0] duty_val;
  logic [P_CNT_W-1:0]  cnt_val;
  logic [P_CNT_W-1:0]  low_mask;

  tick_pwm_regs #(
    .P_ADDR_W (P_ADDR_W),
    .P_DATA_W (P_DATA_W),
    .P_PSC_W  (P_PSC_W),
    .P_DUTY_W (L_DUTY_W),
    .P_EN_BIT (CTRL_EN_BIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctrl_en   (ctrl_en),
    .ctrl_psc  (ctrl_psc),
    .duty      (duty_val)
  );

  tick_pwm_counter #(
    .P_CNT_W (P_CNT_W),
    .P_PSC_W (P_PSC_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_en),
    .tick     (tick),
    .psc      (ctrl_psc),
    .cnt      (cnt_val),
    .low_mask (low_mask)
  );

  tick_pwm_cmp #(
    .P_CNT_W  (P_CNT_W),
    .P_DUTY_W (L_DUTY_W)
  ) u_cmp (
    .en       (ctrl_en),
    .cnt      (cnt_val),
    .low_mask (low_mask),
    .duty     (duty_val),
    .pwm      (pwm_out)
  );

endmodule

// File: rtl/tick_pwm_chk.sv
module tick_pwm_chk
  import tick_pwm_pkg::*;
#(
  parameter int P_CNT_W  = CNT_W,
  parameter int P_PSC_W  = PSC_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_DATA_W = DATA_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 en,
  input logic [P_PSC_W-1:0]   psc,
  input logic [P_CNT_W-2:0]   duty,
  input logic [P_CNT_W-1:0]   cnt,
  input logic [P_ADDR_W-1:0]  reg_addr,
  input logic [P_DATA_W-1:0]  reg_rdata,
  input logic                 pwm_out
);

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out); // R6

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R6

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt)); // R4

  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick) |=> ((cnt == $past(cnt) + P_CNT_W'(1)) || (cnt == '0))); // R4

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !pwm_out); // R5

  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (psc != '0) && (&duty)) |-> pwm_out); // R5

  AST_RSVD_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_addr) == P_ADDR_W'(ADDR_CTRL)) |->
      (reg_rdata[CTRL_EN_BIT-1:P_PSC_W] == '0)); // R3

  AST_RSVD_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_addr) == P_ADDR_W'(ADDR_DUTY)) |->
      (reg_rdata[P_DATA_W-1] == 1'b0)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_addr) > P_ADDR_W'(ADDR_DUTY)) |-> (reg_rdata == '0)); // R2

endmodule

bind tick_pwm tick_pwm_chk #(
  .P_CNT_W  (P_CNT_W),
  .P_PSC_W  (P_PSC_W),
  .P_ADDR_W (P_ADDR_W),
  .P_DATA_W (P_DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .en        (ctrl_en),
  .psc       (ctrl_psc),
  .duty      (duty_val),
  .cnt       (cnt_val),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .pwm_out   (pwm_out)
);

// File: tb/tb_tick_pwm.sv
module tb_tick_pwm;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       pwm_out;

  always #2 clk = ~clk;

  tick_pwm dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit armed = 1'b0;
  bit done  = 1'b0;

  // Reference state, built from the requirements
  logic       m_en;
  logic [1:0] m_psc;
  logic [6:0] m_duty;
  logic [7:0] m_cnt;
  logic [7:0] m_rd;
  logic [7:0] m_nx;

  function automatic logic exp_out(logic en, logic [1:0] p, logic [6:0] d, logic [7:0] c);
    logic [7:0] mask;
    mask = (8'd1 << (7 - p)) - 8'd1;
    return en && ((c & mask) < {1'b0, d});
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] a, logic en, logic [1:0] p, logic [6:0] d);
    if (a == 2'd0) return {en, 5'd0, p};
    if (a == 2'd1) return {1'b0, d};
    return 8'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= 1'b0; m_psc <= 2'd0; m_duty <= 7'd0; m_cnt <= 8'd0; m_rd <= 8'd0;
    end else begin
      m_rd <= exp_rd(reg_addr, m_en, m_psc, m_duty);
      if (reg_we && reg_addr == 2'd0) begin
        m_en  <= reg_wdata[7];
        m_psc <= reg_wdata[1:0];
      end
      if (reg_we && reg_addr == 2'd1) m_duty <= reg_wdata[6:0];
      m_nx = m_cnt + 8'd1;
      if (!m_en)     m_cnt <= 8'd0;
      else if (tick) m_cnt <= m_nx[7 - m_psc] ? 8'd0 : m_nx;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (armed && !done) begin
      check("R5 output vs model", {31'd0, pwm_out}, {31'd0, exp_out(m_en, m_psc, m_duty, m_cnt)});
      check("R2 read data vs model", {24'd0, reg_rdata}, {24'd0, m_rd});
    end
  end

  // All tasks are entered and left at a falling edge
  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic count_high(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      h += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int h;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R1 output in reset", {31'd0, pwm_out}, 32'd0);
    check("R1 read data in reset", {24'd0, reg_rdata}, 32'd0);
    rst_n = 1'b1;
    armed = 1'b1;
    tick  = 1'b1;

    rd(2'd0, v); check("R1 control after reset", {24'd0, v}, 32'h00);
    rd(2'd1, v); check("R1 duty after reset", {24'd0, v}, 32'h00);

    // Register map and reserved bits
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R3 control reserved bits", {24'd0, v}, 32'h83);
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R3 duty reserved bit", {24'd0, v}, 32'h7F);
    rd(2'd2, v); check("R2 unmapped address 2", {24'd0, v}, 32'h00);
    rd(2'd3, v); check("R2 unmapped address 3", {24'd0, v}, 32'h00);
    wr(2'd0, 8'h81); rd(2'd0, v); check("R2 control readback", {24'd0, v}, 32'h81);

    // Disable forces low; enable restarts from zero
    wr(2'd1, 8'd127); wr(2'd0, 8'h00);
    count_high(20, h); check("R6 disabled output low", h, 0);
    wr(2'd1, 8'd5); wr(2'd0, 8'h83);
    count_high(32, h); check("R6 start from zero", h, 10);

    // Period for each prescaler
    for (int p = 0; p < 4; p++) begin
      wr(2'd0, 8'h00); wr(2'd1, 8'd1); wr(2'd0, 8'h80 | 8'(p));
      count_high(4 << (7 - p), h); check("R4 period per prescaler", h, 4);
    end

    // No tick, no advance
    wr(2'd0, 8'h00); wr(2'd1, 8'd1);
    tick = 1'b0;
    wr(2'd0, 8'h83);
    count_high(20, h); check("R4 counter holds without tick", h, 20);
    tick = 1'b1;

    // Duty extremes
    wr(2'd0, 8'h00); wr(2'd1, 8'd127); wr(2'd0, 8'h80);
    count_high(256, h); check("R5 prescaler 0 full duty", h, 254);
    wr(2'd0, 8'h00); wr(2'd1, 8'd16); wr(2'd0, 8'h83);
    count_high(64, h); check("R5 duty equal to period", h, 64);
    wr(2'd1, 8'd0);
    count_high(32, h); check("R5 zero duty", h, 0);

    // Prescaler switch keeps the count
    wr(2'd0, 8'h00); wr(2'd1, 8'd64); wr(2'd0, 8'h80);
    repeat (98) @(negedge clk);
    wr(2'd1, 8'd10); wr(2'd0, 8'h83);
    count_high(12, h); check("R7 count kept across prescaler change", h, 6);
    count_high(16, h); check("R7 first full period after switch", h, 10);

    // Duty takes effect immediately
    wr(2'd0, 8'h00); wr(2'd1, 8'd0); wr(2'd0, 8'h80);
    repeat (10) @(negedge clk);
    check("R8 low before duty write", {31'd0, pwm_out}, 32'd0);
    wr(2'd1, 8'd127);
    check("R8 high right after duty write", {31'd0, pwm_out}, 32'd1);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'd0);
    check("R8 low right after duty clear", {31'd0, pwm_out}, 32'd0);

    // Constrained random traffic, compared every cycle with the model
    for (int i = 0; i < 4000; i++) begin
      tick = 1'($urandom % 2);
      if (($urandom % 8) == 0) begin
        reg_we = 1'b1;
        reg_addr = 2'($urandom % 4);
        reg_wdata = 8'($urandom);
      end else begin
        reg_we = 1'b0;
        reg_addr = 2'($urandom % 4);
      end
      @(negedge clk);
    end
    reg_we = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule